// File: doc/BRIEF.md
# Protected scratchpad commit controller

This block guards a small on-chip memory of four 32-byte data pages, an 8-byte register page and an 8-byte secret. A host never writes the memory directly. It first selects an aligned 8-byte target and fills an 8-byte scratchpad one byte at a time. It can read the scratchpad back to verify it. It then issues a copy command.

The copy moves all eight bytes to the target in one step, but only when a 160-bit authorisation code from the host equals a 160-bit reference produced by an external hash engine. The one exception is the secret: it is installed without that match. The secret is presented on an output so the hash engine can use it.

Page protection and a clear-only mode for page 1 are coded in the register page. The block samples them while reset is held and keeps them until the next reset. Each copy, whether accepted or refused, holds the block busy for a fixed number of cycles.

Top module: `sp_commit_ctrl`

## Requirements
- R1: The byte address map is as follows. Data pages sit at 0x00-0x7F, with page n at 0x20*n. The register page sits at 0x80-0x87, the secret at 0x88-0x8F, and 0x90 and above are invalid. A memory read (op 4) returns the stored byte on `rd_data` with `rd_valid` high one cycle after it is accepted. Secret and invalid addresses read as 0x00.
- R2: A target load (op 0) sets `sp_target` to `cmd_addr` with its low three bits cleared. It resets the fill position to 0 and clears `sp_status`. After reset, target and status are 0x00.
- R3: A push (op 1) stores `cmd_data` at the fill position and advances it, wrapping from 7 back to 0. A peek (op 2) returns scratchpad byte `cmd_addr[2:0]` one cycle later. Scratchpad byte i is destined for target address + i.
- R4: A copy (op 3) to a data or register-page target with `auth_code == hash_ref` writes all eight bytes and sets `sp_status` to 0x01. The status never has more than one bit set.
- R5: A copy with `auth_code != hash_ref` to a data or register-page target leaves memory unchanged and sets `sp_status` to 0x02.
- R6: A copy to the secret target (0x88) commits whatever the codes are and sets `sp_status` to 0x01. `secret_out` then holds the eight bytes, with byte i at bits 8i+7:8i.
- R7: Register byte 0x80, as sampled at reset, selects protection: 0xA5 protects page 0, 0x5A protects page 3, 0xC3 protects all four data pages, and any other value protects none. A copy to a protected page writes nothing and sets `sp_status` to 0x04. This check comes before the code comparison.
- R8: When register byte 0x81 reads 0x96 at reset, a copy to page 1 stores the bitwise AND of the old and new bytes, so bits only clear. Other pages are stored as written.
- R9: Changes to the register page have no effect on protection or clear-only mode until the next reset.
- R10: Every accepted copy raises `busy` for COMMIT_CYCLES cycles, starting the cycle after acceptance. While `busy` is high, all commands are ignored and produce no read response.
- R11: A copy whose target is 0x90 or above writes nothing and sets `sp_status` to 0x08. Op codes 5-7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; protection settings are sampled while it is high |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | 0 load target, 1 push, 2 peek, 3 copy, 4 memory read |
| cmd_addr | input | 8 | Target, read address or peek index |
| cmd_data | input | 8 | Byte for push |
| auth_code | input | 160 | Host-supplied authorisation code |
| hash_ref | input | 160 | Reference code from the external hash engine |
| busy | output | 1 | Copy in progress; commands ignored |
| rd_valid | output | 1 | Read or peek response valid |
| rd_data | output | 8 | Read or peek response byte |
| sp_target | output | 8 | Aligned scratchpad target address |
| sp_status | output | 8 | Outcome of last copy: 0x01 done, 0x02 code mismatch, 0x04 protected, 0x08 invalid target |
| secret_out | output | 64 | Stored secret, for the hash engine |

## Verification
Several properties are checked on every cycle. The target stays aligned, and scratchpad state holds still while busy. No write happens to a protected page or without a code match, except for the secret. A clear-only page never gains a set bit across a commit. The latched settings never move outside reset, and the status keeps at most one bit set. Other behaviour needs bench scenarios: the exact busy length, the wrap of the fill position, the AND merge values, and that register-page edits only act after a second reset.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int PAGES       = 4;
    localparam int PAGE_BYTES  = 32;
    localparam int BLK_BYTES   = 8;
    localparam int MAC_W       = 160;
    localparam int AW          = 8;
    localparam int DATA_BYTES  = PAGES * PAGE_BYTES;
    localparam int REG_BASE    = DATA_BYTES;
    localparam int SECRET_BASE = REG_BASE + BLK_BYTES;
    localparam int SPACE_END   = SECRET_BASE + BLK_BYTES;
    localparam int BLK_W       = BLK_BYTES * 8;
    localparam int IDX_W       = $clog2(BLK_BYTES);
    localparam int PG_W        = $clog2(PAGES);
    localparam int PB_W        = $clog2(PAGE_BYTES);
    localparam int DB_W        = $clog2(DATA_BYTES);
    localparam int OTP_PAGE    = 1;

    localparam logic [7:0] CODE_PROT_FIRST = 8'hA5;
    localparam logic [7:0] CODE_PROT_LAST  = 8'h5A;
    localparam logic [7:0] CODE_PROT_ALL   = 8'hC3;
    localparam logic [7:0] CODE_OTP        = 8'h96;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_PUSH  = 3'd1,
        OP_PEEK  = 3'd2,
        OP_COPY  = 3'd3,
        OP_RDMEM = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        TGT_DATA,
        TGT_REG,
        TGT_SECRET,
        TGT_BAD
    } tgt_e;

    typedef struct packed {
        logic [PAGES-1:0] prot;
        logic             otp;
    } cfg_t;

    // bit order gives the status byte layout: bad, prot, auth, ok
    typedef struct packed {
        logic bad_target;
        logic prot_err;
        logic auth_err;
        logic ok;
    } verdict_t;

    function automatic tgt_e classify(input logic [AW-1:0] a);
        if (int'(a) < DATA_BYTES)       return TGT_DATA;
        else if (int'(a) < SECRET_BASE) return TGT_REG;
        else if (int'(a) < SPACE_END)   return TGT_SECRET;
        else                            return TGT_BAD;
    endfunction

    function automatic cfg_t decode_cfg(input logic [7:0] prot_b, input logic [7:0] otp_b);
        cfg_t c;
        c.prot = '0;
        if (prot_b == CODE_PROT_FIRST)      c.prot[0]       = 1'b1;
        else if (prot_b == CODE_PROT_LAST)  c.prot[PAGES-1] = 1'b1;
        else if (prot_b == CODE_PROT_ALL)   c.prot          = '1;
        c.otp = (otp_b == CODE_OTP);
        return c;
    endfunction

endpackage

// File: rtl/spc_scratchpad.sv
module spc_scratchpad
    import spc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              busy_i,
    input  op_e               op_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [7:0]        data_i,
    output logic [AW-1:0]     target_o,
    output logic [BLK_W-1:0]  buf_o,
    output logic [7:0]        peek_o
);

    logic [7:0]       bytes_q [BLK_BYTES];
    logic [IDX_W-1:0] idx_q;
    logic [AW-1:0]    target_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= '0;
            idx_q    <= '0;
            for (int i = 0; i < BLK_BYTES; i++) bytes_q[i] <= '0;
        end else if (accept_i) begin
            case (op_i)
                OP_LOAD: begin
                    target_q <= {addr_i[AW-1:IDX_W], {IDX_W{1'b0}}};
                    idx_q    <= '0;
                end
                OP_PUSH: begin
                    bytes_q[idx_q] <= data_i;
                    idx_q          <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < BLK_BYTES; g++) begin : g_pack
        assign buf_o[g*8 +: 8] = bytes_q[g];
    end

    assign target_o = target_q;
    assign peek_o   = bytes_q[addr_i[IDX_W-1:0]];

    p_target_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        target_q[IDX_W-1:0] == '0);

    p_hold_while_busy_r10: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> ($stable(target_q) && $stable(idx_q) && $stable(buf_o)));

endmodule

// File: rtl/spc_guard.sv
module spc_guard
    import spc_pkg::*;
(
    input  logic [AW-1:0]    target_i,
    input  logic [BLK_W-1:0] sp_i,
    input  logic [BLK_W-1:0] old_i,
    input  logic [MAC_W-1:0] auth_i,
    input  logic [MAC_W-1:0] ref_i,
    input  cfg_t             cfg_i,
    output verdict_t         verdict_o,
    output logic             otp_hit_o,
    output logic [BLK_W-1:0] wdata_o
);

    tgt_e            tgt;
    logic [PG_W-1:0] page;
    logic            match;

    assign tgt   = classify(target_i);
    assign page  = target_i[DB_W-1:PB_W];
    assign match = (auth_i == ref_i);

    // priority: invalid target, then protection, then code comparison
    always_comb begin
        verdict_o = '0;
        if (tgt == TGT_BAD)
            verdict_o.bad_target = 1'b1;
        else if (tgt == TGT_DATA && cfg_i.prot[page])
            verdict_o.prot_err = 1'b1;
        else if (tgt != TGT_SECRET && !match)
            verdict_o.auth_err = 1'b1;
        else
            verdict_o.ok = 1'b1;
    end

    assign otp_hit_o = (tgt == TGT_DATA) && cfg_i.otp && (page == PG_W'(OTP_PAGE));
    assign wdata_o   = otp_hit_o ? (old_i & sp_i) : sp_i;

endmodule

// File: rtl/spc_store.sv
module spc_store
    import spc_pkg::*;
(
    input  logic             clk,
    input  logic             we_i,
    input  logic [AW-1:0]    blk_addr_i,
    input  logic [BLK_W-1:0] wdata_i,
    output logic [BLK_W-1:0] blk_o,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [7:0]       rd_byte_o,
    output logic [7:0]       prot_byte_o,
    output logic [7:0]       otp_byte_o,
    output logic [BLK_W-1:0] secret_o
);

    logic [7:0]       data_q [DATA_BYTES];
    logic [7:0]       reg_q  [BLK_BYTES];
    logic [BLK_W-1:0] secret_q;
    tgt_e             wtgt;
    tgt_e             rtgt;

    assign wtgt = classify(blk_addr_i);
    assign rtgt = classify(rd_addr_i);

    // non-volatile contents: no reset
    always_ff @(posedge clk) begin
        if (we_i) begin
            case (wtgt)
                TGT_DATA:
                    for (int b = 0; b < BLK_BYTES; b++)
                        data_q[{blk_addr_i[DB_W-1:IDX_W], IDX_W'(b)}] <= wdata_i[b*8 +: 8];
                TGT_REG:
                    for (int b = 0; b < BLK_BYTES; b++)
                        reg_q[b] <= wdata_i[b*8 +: 8];
                TGT_SECRET:
                    secret_q <= wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        blk_o = '0;
        for (int b = 0; b < BLK_BYTES; b++) begin
            case (wtgt)
                TGT_DATA: blk_o[b*8 +: 8] = data_q[{blk_addr_i[DB_W-1:IDX_W], IDX_W'(b)}];
                TGT_REG:  blk_o[b*8 +: 8] = reg_q[b];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (rtgt)
            TGT_DATA: rd_byte_o = data_q[rd_addr_i[DB_W-1:0]];
            TGT_REG:  rd_byte_o = reg_q[rd_addr_i[IDX_W-1:0]];
            default:  rd_byte_o = 8'h00;
        endcase
    end

    assign prot_byte_o = reg_q[0];
    assign otp_byte_o  = reg_q[1];
    assign secret_o    = secret_q;

endmodule

// File: rtl/sp_commit_ctrl.sv
module sp_commit_ctrl
    import spc_pkg::*;
#(
    parameter int COMMIT_CYCLES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [AW-1:0]      cmd_addr,
    input  logic [7:0]         cmd_data,
    input  logic [MAC_W-1:0]   auth_code,
    input  logic [MAC_W-1:0]   hash_ref,
    output logic               busy,
    output logic               rd_valid,
    output logic [7:0]         rd_data,
    output logic [AW-1:0]      sp_target,
    output logic [7:0]         sp_status,
    output logic [BLK_W-1:0]   secret_out
);

    localparam int CW = $clog2(COMMIT_CYCLES + 1);

    logic [CW-1:0]    cnt_q;
    logic [7:0]       status_q;
    logic             rd_valid_q;
    logic [7:0]       rd_data_q;
    cfg_t             cfg_q;

    op_e              op;
    logic             accept;
    logic             is_copy;
    logic             wr_en;
    logic [AW-1:0]    target;
    logic [BLK_W-1:0] sp_buf;
    logic [7:0]       peek_byte;
    logic [BLK_W-1:0] blk_old;
    logic [BLK_W-1:0] wdata;
    logic [7:0]       rd_byte;
    logic [7:0]       prot_byte;
    logic [7:0]       otp_byte;
    logic             otp_hit;
    verdict_t         verdict;

    assign op      = op_e'(cmd_op);
    assign busy    = (cnt_q != '0);
    assign accept  = cmd_valid && !busy;
    assign is_copy = accept && (op == OP_COPY);
    assign wr_en   = is_copy && verdict.ok;

    spc_scratchpad u_sp (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .busy_i   (busy),
        .op_i     (op),
        .addr_i   (cmd_addr),
        .data_i   (cmd_data),
        .target_o (target),
        .buf_o    (sp_buf),
        .peek_o   (peek_byte)
    );

    spc_guard u_guard (
        .target_i  (target),
        .sp_i      (sp_buf),
        .old_i     (blk_old),
        .auth_i    (auth_code),
        .ref_i     (hash_ref),
        .cfg_i     (cfg_q),
        .verdict_o (verdict),
        .otp_hit_o (otp_hit),
        .wdata_o   (wdata)
    );

    spc_store u_store (
        .clk         (clk),
        .we_i        (wr_en),
        .blk_addr_i  (target),
        .wdata_i     (wdata),
        .blk_o       (blk_old),
        .rd_addr_i   (cmd_addr),
        .rd_byte_o   (rd_byte),
        .prot_byte_o (prot_byte),
        .otp_byte_o  (otp_byte),
        .secret_o    (secret_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            status_q   <= '0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
            cfg_q      <= decode_cfg(prot_byte, otp_byte);
        end else begin
            rd_valid_q <= 1'b0;
            if (busy) cnt_q <= cnt_q - 1'b1;
            if (accept) begin
                case (op)
                    OP_LOAD:  status_q <= '0;
                    OP_PEEK: begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= peek_byte;
                    end
                    OP_RDMEM: begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= rd_byte;
                    end
                    OP_COPY: begin
                        cnt_q    <= CW'(COMMIT_CYCLES);
                        status_q <= {4'b0000, verdict};
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;
    assign sp_target = target;
    assign sp_status = status_q;

    p_read_resp_r1: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_RDMEM) |=> rd_valid);

    p_status_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sp_status));

    p_code_needed_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && classify(target) != TGT_SECRET) |-> (auth_code == hash_ref));

    p_protect_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && classify(target) == TGT_DATA) |-> !cfg_q.prot[target[DB_W-1:PB_W]]);

    p_otp_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && otp_hit) |=> ((blk_old & ~$past(blk_old)) == '0));

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(cfg_q));

    p_copy_busy_r10: assert property (@(posedge clk) disable iff (rst)
        is_copy |=> busy);

    p_busy_silent_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> !rd_valid);

    p_bad_no_write_r11: assert property (@(posedge clk) disable iff (rst)
        (is_copy && classify(target) == TGT_BAD) |-> !wr_en);

endmodule

// File: tb/sp_commit_ctrl_tb.sv
`timescale 1ns/1ps
module sp_commit_ctrl_tb;
    import spc_pkg::*;

    localparam int CYC = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = '0;
    logic [7:0]       cmd_addr = '0;
    logic [7:0]       cmd_data = '0;
    logic [MAC_W-1:0] auth_code = '0;
    logic [MAC_W-1:0] hash_ref = {5{32'h9E3779B9}};
    logic             busy;
    logic             rd_valid;
    logic [7:0]       rd_data;
    logic [7:0]       sp_target;
    logic [7:0]       sp_status;
    logic [63:0]      secret_out;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] mdl [SECRET_BASE];
    bit         m_otp = 0;

    sp_commit_ctrl #(.COMMIT_CYCLES(CYC)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .auth_code(auth_code),
        .hash_ref(hash_ref), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .sp_target(sp_target), .sp_status(sp_status), .secret_out(secret_out)
    );

    always #10 clk = ~clk;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // monitor: scoreboard pops one expectation per response
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                nchk++; nfail++;
                $display("FAIL R10 unexpected response act=%h exp=none", rd_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                check(t, {56'd0, rd_data}, {56'd0, e});
            end
        end
    end

    task automatic issue(op_e op, logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd_mem(logic [7:0] a, logic [7:0] e, string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        issue(OP_RDMEM, a, 8'h00);
    endtask

    task automatic peek(logic [7:0] i, logic [7:0] e, string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        issue(OP_PEEK, i, 8'h00);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [63:0] pat(logic [7:0] b);
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = b + 8'(i);
        return v;
    endfunction

    task automatic copy_blk(bit good, logic [7:0] exp_st, string tag);
        auth_code = good ? hash_ref : (hash_ref ^ 160'h1);
        issue(OP_COPY, 8'h00, 8'h00);
        check("R10 busy after copy", {63'd0, busy}, 64'd1);
        repeat (CYC - 1) @(negedge clk);
        check("R10 busy last cycle", {63'd0, busy}, 64'd1);
        @(negedge clk);
        check("R10 busy released", {63'd0, busy}, 64'd0);
        check(tag, {56'd0, sp_status}, {56'd0, exp_st});
    endtask

    task automatic write_blk(logic [7:0] a, logic [63:0] v, bit good, logic [7:0] exp_st, string tag);
        automatic int t = int'({a[7:3], 3'b000});
        issue(OP_LOAD, a, 8'h00);
        for (int i = 0; i < 8; i++) issue(OP_PUSH, 8'h00, v[i*8 +: 8]);
        copy_blk(good, exp_st, tag);
        if (exp_st == 8'h01 && t < SECRET_BASE)
            for (int i = 0; i < 8; i++)
                mdl[t+i] = (m_otp && t >= 32 && t < 64) ? (mdl[t+i] & v[i*8 +: 8]) : v[i*8 +: 8];
    endtask

    task automatic verify_blk(logic [7:0] a, string tag);
        for (int i = 0; i < 8; i++) rd_mem(a + 8'(i), mdl[int'(a) + i], tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R10 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R2 reset status", {56'd0, sp_status}, 64'd0);
        check("R2 reset target", {56'd0, sp_target}, 64'd0);
        check("R10 reset busy", {63'd0, busy}, 64'd0);
        check("R1 reset rd_valid", {63'd0, rd_valid}, 64'd0);

        // clean register page, then data blocks
        write_blk(8'h80, pat(8'h00), 1, 8'h01, "R4 register page commit");
        write_blk(8'h00, pat(8'h10), 1, 8'h01, "R4 page0 commit");
        write_blk(8'h23, pat(8'h01), 1, 8'h01, "R4 page1 commit");
        check("R2 unaligned target", {56'd0, sp_target}, 64'h20);
        write_blk(8'h60, pat(8'h70), 1, 8'h01, "R4 page3 commit");
        write_blk(8'h40, pat(8'h50), 1, 8'h01, "R4 page2 commit");
        verify_blk(8'h00, "R1 read page0");
        verify_blk(8'h20, "R1 read page1");
        verify_blk(8'h60, "R1 read page3");
        verify_blk(8'h40, "R4 read page2");
        rd_mem(8'h81, 8'h01, "R1 register byte read");

        // scratchpad readback and wrap
        peek(8'h05, 8'h55, "R3 peek index5");
        issue(OP_LOAD, 8'h40, 8'h00);
        check("R2 load clears status", {56'd0, sp_status}, 64'd0);
        for (int i = 0; i < 9; i++) issue(OP_PUSH, 8'h00, 8'hA0 + 8'(i));
        peek(8'h00, 8'hA8, "R3 wrap overwrote index0");
        peek(8'h01, 8'hA1, "R3 index1 kept");

        // mismatching code
        write_blk(8'h00, pat(8'h33), 0, 8'h02, "R5 mismatch status");
        verify_blk(8'h00, "R5 memory unchanged");

        // secret without match
        write_blk(8'h8C, pat(8'hC0), 0, 8'h01, "R6 secret commit");
        check("R6 secret value", secret_out, pat(8'hC0));
        rd_mem(8'h88, 8'h00, "R1 secret reads zero");

        // invalid target and op
        write_blk(8'h97, pat(8'h11), 1, 8'h08, "R11 invalid target");
        rd_mem(8'h90, 8'h00, "R1 invalid reads zero");
        issue(op_e'(3'd6), 8'h00, 8'h00);
        check("R11 unknown op no busy", {63'd0, busy}, 64'd0);

        // protect page0 + clear-only page1, not yet in effect
        write_blk(8'h80, {pat(8'h00)[63:16], 8'h96, 8'hA5}, 1, 8'h01, "R4 config written");
        write_blk(8'h00, pat(8'h20), 1, 8'h01, "R9 page0 still open");
        write_blk(8'h20, pat(8'h01), 1, 8'h01, "R9 page1 not yet clear-only");
        verify_blk(8'h20, "R9 page1 stored as written");

        do_reset();
        m_otp = 1;
        write_blk(8'h00, pat(8'h44), 1, 8'h04, "R7 page0 protected");
        write_blk(8'h00, pat(8'h44), 0, 8'h04, "R7 protection before code");
        verify_blk(8'h00, "R7 page0 unchanged");
        write_blk(8'h60, pat(8'h99), 1, 8'h01, "R7 page3 open");
        write_blk(8'h20, pat(8'h0F), 1, 8'h01, "R8 clear-only commit");
        verify_blk(8'h20, "R8 page1 holds AND");
        write_blk(8'h40, pat(8'h0F), 1, 8'h01, "R8 page2 plain");
        verify_blk(8'h40, "R8 page2 stored as written");

        // protect page3 only
        write_blk(8'h80, {pat(8'h00)[63:8], 8'h5A}, 1, 8'h01, "R4 config page3");
        do_reset();
        m_otp = 0;
        write_blk(8'h60, pat(8'h12), 1, 8'h04, "R7 page3 protected");
        write_blk(8'h00, pat(8'h66), 1, 8'h01, "R7 page0 open");
        verify_blk(8'h60, "R7 page3 unchanged");

        // protect all
        write_blk(8'h80, {pat(8'h00)[63:8], 8'hC3}, 1, 8'h01, "R4 config all");
        do_reset();
        write_blk(8'h48, pat(8'h21), 1, 8'h04, "R7 all pages protected");
        write_blk(8'h80, pat(8'h00), 1, 8'h01, "R4 register page writable");

        // commands ignored while busy
        issue(OP_LOAD, 8'h40, 8'h00);
        for (int i = 0; i < 8; i++) issue(OP_PUSH, 8'h00, 8'h30 + 8'(i));
        auth_code = hash_ref;
        issue(OP_COPY, 8'h00, 8'h00);
        issue(OP_PUSH, 8'h00, 8'hEE);
        issue(OP_LOAD, 8'h08, 8'h00);
        issue(OP_RDMEM, 8'h00, 8'h00);
        while (busy) @(negedge clk);
        check("R10 target kept while busy", {56'd0, sp_target}, 64'h40);
        peek(8'h00, 8'h30, "R10 push ignored while busy");

        repeat (4) @(negedge clk);
        check("R1 all responses seen", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule